// File: doc/BRIEF.md
# Lazy Condition-Flag Resolver

This block turns a saved arithmetic record into the four condition flags of a 32-bit integer core. The core does not work out negative, zero, overflow and carry after every instruction. It keeps three things instead: a code naming the kind of the last flag-setting operation, the source operand of that operation, and its result. The flags are resolved only when a later instruction needs them. Overflow and carry are rebuilt from the result and the source alone. The first operand is recovered by undoing the operation, so no adder carry chain has to be kept.

A request presents the kind code, the source word and the result word, with a one-cycle strobe. The resolved flags appear on a registered output in the cycle after the strobe. The resolved flags can then be fed back as the result word of a pass-through request, so a record that has already been resolved costs nothing to resolve again. The 8-bit and 16-bit compares take every flag from the narrow width. For the extended add and subtract, zero is cumulative across a chain of operations. An unrecognised kind code is reported on an error output and leaves the stored flags unchanged.

Top module: `ccf_resolver`

## Requirements
- R1: While reset is asserted, and right after it is released, `flags_o` is 0 and `err_o` is 0.
- R2: The flag word is packed as C in bit 0, V in bit 1, Z in bit 2 and N in bit 3. With kind 0 (pass-through), the next `flags_o` equals bits 3..0 of `res_i`.
- R3: With kind 1 (logic), Z is set when the result is zero. N is set when the result is nonzero and its bit 31 is 1. V and C are 0.
- R4: With kind 2 (add), the first operand is taken as result − source. C is set when result < source, unsigned. V is set on signed overflow of first operand + source. N and Z come from the 32-bit result.
- R5: With kind 3 (subtract), the first operand is taken as result + source. C is set when that operand < source, unsigned. V is set on signed overflow of operand − source. N and Z come from the 32-bit result.
- R6: Kinds 4 (8-bit compare) and 5 (16-bit compare) follow R5 but use only the low 8 or 16 bits of the source and the result. N, Z, V and C all come from that width.
- R7: With kind 6 (add with extend), C is set when result ≤ source, and V comes from first operand + source + 1, where the first operand is result − source − 1. With kind 7 (subtract with extend), the first operand is result + source + 1, C is set when that operand ≤ source, and V comes from operand − source − 1.
- R8: For kinds 6 and 7, Z is the zero test of the result ANDed with the Z bit of the previously stored flags. These kinds can clear Z but never set it.
- R9: With kind 8 (shift), N and Z come from the 32-bit result, V is 0, and C is set exactly when the source word is nonzero.
- R10: A strobe with a kind code of 9 to 15 sets `err_o` for the following cycle and leaves `flags_o` unchanged.
- R11: Flags and error update only on the clock edge that samples `eval_i` high. Without a strobe, `flags_o` holds its value and `err_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Resolve strobe, one cycle per request |
| kind_i | input | 4 | Kind code of the saved operation |
| src_i | input | 32 | Saved source operand |
| res_i | input | 32 | Saved result, or packed flags for pass-through |
| flags_o | output | 4 | Resolved flags {N, Z, V, C} |
| err_o | output | 1 | High for one cycle after a request with an unknown kind |

## Verification
Directed vectors cover each kind at the edges where the recovered operand wraps. These include carry out of all ones plus one, and signed overflow at 0x7FFFFFFF plus one. They also include borrow from zero minus one, a zero source, and byte and halfword compares whose narrow sign differs from bit 31. These vectors separate the unsigned carry test from the signed overflow test, and the narrow lane from the full-width one. Chains of extended operations that start with Z set and with Z clear separate the sticky AND from a plain zero test. Randomised requests mix every code, including unknown ones, with idle cycles. The resulting flags are checked against a model that computes true carries and overflows in wide integer arithmetic. This model does not use the result-based recovery rules.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

   localparam int KIND_W = 4;

   // Operation kinds that the resolver understands
   typedef enum logic [KIND_W-1:0] {
      CK_PASS  = 4'd0,
      CK_LOGIC = 4'd1,
      CK_ADD   = 4'd2,
      CK_SUB   = 4'd3,
      CK_CMP8  = 4'd4,
      CK_CMP16 = 4'd5,
      CK_ADDX  = 4'd6,
      CK_SUBX  = 4'd7,
      CK_SHIFT = 4'd8
   } ccf_kind_e;

   // Bit positions inside the packed flag word
   localparam int FLG_C = 0;
   localparam int FLG_V = 1;
   localparam int FLG_Z = 2;
   localparam int FLG_N = 3;
   localparam int FLG_W = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccf_flags_t;

endpackage

// File: rtl/ccf_nz.sv
// Zero and negative detection over a lane of width W; N only when nonzero
module ccf_nz #(
   parameter int W = 32
) (
   input  logic [W-1:0] val_i,
   output logic         n_o,
   output logic         z_o
);
   if (W < 2) begin : g_bad_w
      $error("ccf_nz: lane width must be at least 2");
   end

   always_comb begin
      z_o = (val_i == '0);
      n_o = !z_o && val_i[W-1];
   end
endmodule

// File: rtl/ccf_sub_rec.sv
// Recovers carry and overflow of a subtraction from its result and source.
// EXT selects the variant with an extra borrow-in of one.
module ccf_sub_rec #(
   parameter int W   = 32,
   parameter bit EXT = 1'b0
) (
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] res_i,
   output logic         c_o,
   output logic         v_o
);
   logic [W-1:0] minuend;
   logic [W-1:0] ovf_vec;

   always_comb begin
      minuend = res_i + src_i + W'(EXT);
      ovf_vec = (minuend ^ res_i) & (minuend ^ src_i);
      v_o     = ovf_vec[W-1];
   end

   if (EXT) begin : g_ext
      always_comb c_o = (minuend <= src_i);
   end else begin : g_plain
      always_comb c_o = (minuend < src_i);
   end
endmodule

// File: rtl/ccf_add_rec.sv
// Recovers carry and overflow of an addition from its result and source.
// EXT selects the variant with an extra carry-in of one.
module ccf_add_rec #(
   parameter int W   = 32,
   parameter bit EXT = 1'b0
) (
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] res_i,
   output logic         c_o,
   output logic         v_o
);
   logic [W-1:0] addend;
   logic [W-1:0] ovf_vec;

   always_comb begin
      addend  = res_i - src_i - W'(EXT);
      ovf_vec = (src_i ^ res_i) & ~(addend ^ src_i);
      v_o     = ovf_vec[W-1];
   end

   if (EXT) begin : g_ext
      always_comb c_o = (res_i <= src_i);
   end else begin : g_plain
      always_comb c_o = (res_i < src_i);
   end
endmodule

// File: rtl/ccf_resolver.sv
module ccf_resolver
   import ccf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              eval_i,
   input  logic [KIND_W-1:0] kind_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] res_i,
   output logic [FLG_W-1:0]  flags_o,
   output logic              err_o
);
   localparam int LANES = 3;
   localparam int LANE_W [LANES] = '{DATA_W, HALF_W, BYTE_W};
   localparam int L_FULL = 0;
   localparam int L_HALF = 1;
   localparam int L_BYTE = 2;

   if (BYTE_W < 2 || HALF_W <= BYTE_W || DATA_W <= HALF_W) begin : g_bad_lanes
      $error("ccf_resolver: lane widths must rise strictly from byte to data");
   end
   if (DATA_W < FLG_W) begin : g_bad_data
      $error("ccf_resolver: data word narrower than the flag word");
   end

   // Per-lane N/Z and subtract recovery (full, half, byte)
   logic [LANES-1:0] ln_n, ln_z, ln_c, ln_v;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      ccf_nz #(.W(LANE_W[g])) u_nz (
         .val_i (res_i[LANE_W[g]-1:0]),
         .n_o   (ln_n[g]),
         .z_o   (ln_z[g])
      );
      ccf_sub_rec #(.W(LANE_W[g]), .EXT(1'b0)) u_sub (
         .src_i (src_i[LANE_W[g]-1:0]),
         .res_i (res_i[LANE_W[g]-1:0]),
         .c_o   (ln_c[g]),
         .v_o   (ln_v[g])
      );
   end

   // Full-width add, add-with-extend and subtract-with-extend recovery
   logic add_c, add_v, addx_c, addx_v, subx_c, subx_v;

   ccf_add_rec #(.W(DATA_W), .EXT(1'b0)) u_add (
      .src_i (src_i), .res_i (res_i), .c_o (add_c), .v_o (add_v)
   );
   ccf_add_rec #(.W(DATA_W), .EXT(1'b1)) u_addx (
      .src_i (src_i), .res_i (res_i), .c_o (addx_c), .v_o (addx_v)
   );
   ccf_sub_rec #(.W(DATA_W), .EXT(1'b1)) u_subx (
      .src_i (src_i), .res_i (res_i), .c_o (subx_c), .v_o (subx_v)
   );

   ccf_flags_t flags_q, flags_nxt;
   logic       kind_ok;
   logic       err_q;

   always_comb begin
      flags_nxt = '0;
      kind_ok   = 1'b1;
      unique case (kind_i)
         CK_PASS:  flags_nxt = ccf_flags_t'(res_i[FLG_W-1:0]);
         CK_LOGIC: begin
            flags_nxt.n = ln_n[L_FULL];
            flags_nxt.z = ln_z[L_FULL];
         end
         CK_ADD:   flags_nxt = '{n: ln_n[L_FULL], z: ln_z[L_FULL], v: add_v, c: add_c};
         CK_SUB:   flags_nxt = '{n: ln_n[L_FULL], z: ln_z[L_FULL], v: ln_v[L_FULL], c: ln_c[L_FULL]};
         CK_CMP8:  flags_nxt = '{n: ln_n[L_BYTE], z: ln_z[L_BYTE], v: ln_v[L_BYTE], c: ln_c[L_BYTE]};
         CK_CMP16: flags_nxt = '{n: ln_n[L_HALF], z: ln_z[L_HALF], v: ln_v[L_HALF], c: ln_c[L_HALF]};
         CK_ADDX:  flags_nxt = '{n: ln_n[L_FULL], z: ln_z[L_FULL] & flags_q.z, v: addx_v, c: addx_c};
         CK_SUBX:  flags_nxt = '{n: ln_n[L_FULL], z: ln_z[L_FULL] & flags_q.z, v: subx_v, c: subx_c};
         CK_SHIFT: begin
            flags_nxt.n = ln_n[L_FULL];
            flags_nxt.z = ln_z[L_FULL];
            flags_nxt.c = (src_i != '0);
         end
         default: begin
            flags_nxt = flags_q;
            kind_ok   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= eval_i && !kind_ok;
         if (eval_i && kind_ok) begin
            flags_q <= flags_nxt;
         end
      end
   end

   assign flags_o = flags_q;
   assign err_o   = err_q;

   // Checks next to the state they guard
   assert_pass_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && kind_i == CK_PASS) |=> flags_o == $past(res_i[FLG_W-1:0]));

   assert_logic_vc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && kind_i == CK_LOGIC) |=> (!flags_o[FLG_V] && !flags_o[FLG_C]));

   assert_nz_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && kind_i >= CK_LOGIC && kind_i <= CK_SHIFT && kind_i != CK_ADDX && kind_i != CK_SUBX)
      |=> !(flags_o[FLG_N] && flags_o[FLG_Z]));

   assert_z_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && (kind_i == CK_ADDX || kind_i == CK_SUBX) && !flags_o[FLG_Z]) |=> !flags_o[FLG_Z]);

   assert_shift_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && kind_i == CK_SHIFT) |=> flags_o[FLG_C] == ($past(src_i) != '0));

   assert_bad_kind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && kind_i > KIND_W'(CK_SHIFT)) |=> (err_o && $stable(flags_o)));

   assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> (!err_o && $stable(flags_o)));

endmodule

// File: tb/ccf_resolver_tb.sv
module ccf_resolver_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eval = 1'b0;
   logic [3:0]  kind = '0;
   logic [31:0] src = '0;
   logic [31:0] res = '0;
   logic [3:0]  flags;
   logic        err;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   ccf_resolver u_dut (
      .clk_i (clk), .rst_ni (rst_n), .eval_i (eval), .kind_i (kind),
      .src_i (src), .res_i (res), .flags_o (flags), .err_o (err)
   );

   // Two's-complement value of a w-bit field, as a wide signed integer
   function automatic longint sx(input longint unsigned v, input int w);
      return (v >> (w-1)) & 1 ? longint'(v) - (longint'(1) << w) : longint'(v);
   endfunction

   // Flags from true carries and overflows of the rebuilt operation
   function automatic logic [3:0] ref_flags(input int k, input logic [31:0] s, input logic [31:0] r,
                                            input logic [3:0] old, output bit bad);
      int w;
      longint unsigned m, su, ru, op;
      longint full, hi, lo;
      bit n, z, v, c;
      bad = 0; v = 0; c = 0; full = 0;
      w  = (k == 4) ? 8 : (k == 5) ? 16 : 32;
      m  = (longint'(1) << w) - 1;
      su = longint'(s) & m;
      ru = longint'(r) & m;
      hi = (longint'(1) << (w-1)) - 1;
      lo = -(longint'(1) << (w-1));
      z  = (ru == 0);
      n  = !z && ((ru >> (w-1)) & 1);
      case (k)
         0: return r[3:0];
         1: ;
         2: begin op = (ru - su) & m;     c = (op + su) > m;     full = sx(op,w) + sx(su,w); end
         3, 4, 5: begin op = (ru + su) & m; c = op < su;        full = sx(op,w) - sx(su,w); end
         6: begin op = (ru - su - 1) & m; c = (op + su + 1) > m; full = sx(op,w) + sx(su,w) + 1; z = z && old[2]; end
         7: begin op = (ru + su + 1) & m; c = op < su + 1;      full = sx(op,w) - sx(su,w) - 1; z = z && old[2]; end
         8: c = (s != 0);
         default: begin bad = 1; return old; end
      endcase
      v = (full > hi) || (full < lo);
      return {n, z, v, c};
   endfunction

   logic [3:0] exp_flags;
   logic       exp_err;
   string      tag = "R1";
   logic [3:0] mf;
   bit         mbad;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_flags <= '0;
         exp_err   <= 1'b0;
         tag       <= "R1";
      end else begin
         exp_err <= 1'b0;
         if (eval) begin
            mf = ref_flags(int'(kind), src, res, exp_flags, mbad);
            if (mbad) exp_err <= 1'b1;
            else      exp_flags <= mf;
            case (kind)
               4'd0: tag <= "R2";
               4'd1: tag <= "R3";
               4'd2: tag <= "R4";
               4'd3: tag <= "R5";
               4'd4, 4'd5: tag <= "R6";
               4'd6, 4'd7: tag <= "R7/R8";
               4'd8: tag <= "R9";
               default: tag <= "R10";
            endcase
         end else begin
            tag <= "R11";
         end
      end
   end

   task automatic compare();
      checks++;
      if (flags !== exp_flags || err !== exp_err) begin
         errors++;
         $display("FAIL %s: flags_o=%h err_o=%b expected flags=%h err=%b", tag, flags, err, exp_flags, exp_err);
      end
   endtask

   // Check the previous request's outcome, then present the next one
   task automatic step(input bit e, input logic [3:0] k, input logic [31:0] s, input logic [31:0] r);
      @(negedge clk);
      compare();
      eval = e; kind = k; src = s; res = r;
   endtask

   task automatic op(input logic [3:0] k, input logic [31:0] s, input logic [31:0] r);
      step(1'b1, k, s, r);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();                    // R1 during reset
      rst_n = 1'b1;
      step(1'b0, 4'd0, '0, '0);     // R1 right after release
      // R2 pass-through
      op(4'd0, 32'h0, 32'hFFFF_FFF5);
      op(4'd0, 32'h1234, 32'h0000_000A);
      // R3 logic
      op(4'd1, 32'h0, 32'h0);
      op(4'd1, 32'h0, 32'h8000_0000);
      op(4'd1, 32'h0, 32'h7FFF_FFFF);
      // R4 add: carry out, signed overflow, both clear
      op(4'd2, 32'h0000_0001, 32'h0000_0000);
      op(4'd2, 32'h0000_0001, 32'h8000_0000);
      op(4'd2, 32'h8000_0000, 32'h0000_0000);
      op(4'd2, 32'h0000_0005, 32'h0000_0008);
      // R5 subtract: borrow, overflow, zero source
      op(4'd3, 32'h0000_0001, 32'hFFFF_FFFF);
      op(4'd3, 32'h0000_0001, 32'h7FFF_FFFF);
      op(4'd3, 32'h0000_0000, 32'h8000_0000);
      op(4'd3, 32'h0000_0003, 32'h0000_0000);
      // R6 narrow compares with upper bits that disagree
      op(4'd4, 32'hFFFF_FF01, 32'h0000_00FF);
      op(4'd4, 32'h0000_0001, 32'hFFFF_FF7F);
      op(4'd4, 32'h1234_5600, 32'h8000_0000);
      op(4'd5, 32'h0000_0001, 32'h0000_FFFF);
      op(4'd5, 32'h0000_0001, 32'h8000_7FFF);
      // R7/R8: Z set first, then extended ops keep or clear it
      op(4'd1, 32'h0, 32'h0);
      op(4'd6, 32'hFFFF_FFFF, 32'h0000_0000);
      op(4'd7, 32'h0000_0000, 32'h0000_0000);
      op(4'd6, 32'h0000_0001, 32'h0000_0005);
      op(4'd7, 32'h0000_0000, 32'h0000_0000);
      op(4'd6, 32'h7FFF_FFFF, 32'h8000_0000);
      op(4'd7, 32'h0000_0001, 32'h7FFF_FFFF);
      op(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      // R9 shift
      op(4'd8, 32'h0000_0001, 32'h0000_0000);
      op(4'd8, 32'h0000_0000, 32'h8000_0000);
      // R10 unknown codes, back to back, then R11 idle
      op(4'd2, 32'h0000_0001, 32'h8000_0000);
      op(4'd9, 32'h0, 32'h0);
      op(4'd15, 32'h0, 32'h0);
      step(1'b0, 4'd12, 32'h0, 32'h0);
      step(1'b0, 4'd1, 32'h0, 32'h0);
      // Mixed random traffic across all codes and idle cycles
      for (int i = 0; i < 600; i++) begin
         logic [31:0] rs, rr;
         rs = $urandom;
         rr = $urandom;
         if (i % 5 == 0) rr = rr & 32'h0000_00FF;
         if (i % 7 == 0) rs = 32'h0;
         step(($urandom % 4) != 0, 4'($urandom % 16), rs, rr);
      end
      step(1'b0, 4'd0, '0, '0);
      step(1'b0, 4'd0, '0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule